// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the SCL clock of an I2C master from a reloadable down-counting rate counter. All counting and line sampling happen only on a one-cycle machine-cycle enable pulse. The block pulls SCL low through an open-drain style enable and otherwise lets the line float. It reads the real line level back through a two-flop synchronizer.

A SCL period starts with a low phase that the master times. When that phase ends, the block releases the line. The counter then stays frozen until the released line is actually seen high, and only then does it reload and time the high phase. As a result, a slave that keeps SCL low stretches the period, but the high phase is never shortened.

The byte-level controller holds `run` high while it needs clocks. It uses the two one-cycle strobes to pace its data path: the low strobe marks the point where SDA may change, and the high strobe marks the point where SCL is confirmed high. In this document a "tick" means one cycle in which `tick` is 1.

Top module: `scl_clock_gen`

## Requirements
- R1: While `run` is 0, `scl_drive_low` is 0 from the next clock on, and no strobe is produced.
- R2: Each low phase begins with a one-cycle `low_strobe` in the cycle `scl_drive_low` rises. It lasts exactly max(`reload`,1) ticks.
- R3: After the low phase the line is released. While an external device holds SCL low, the counter does not advance, so a hold of S ticks adds exactly S ticks to the period.
- R4: After the line is sampled high, the master keeps it released for max(`reload`,1) further ticks. The line is therefore high for max(`reload`,1)+1 ticks, whether or not stretching occurred.
- R5: A `reload` of 0 gives phases of one tick, the same as a `reload` of 1.
- R6: Exactly one `high_strobe` occurs per SCL period, one cycle after the tick on which the synchronized line was seen high. It never coincides with `low_strobe`.
- R7: If `run` falls in the middle of a phase, SCL is released on the next clock.
- R8: During and after reset, SCL is released and both strobes are 0 until the first tick with `run` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Machine-cycle enable, one cycle wide |
| run | input | 1 | Clock request from the byte controller |
| reload | input | RW (7) | Phase length in ticks; 0 is treated as 1 |
| scl_in | input | 1 | Level read back from the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| low_strobe | output | 1 | One-cycle pulse at the start of each low phase |
| high_strobe | output | 1 | One-cycle pulse when the released line is seen high |

## Verification
A counter that is off by one shows up at the ports in the first period: the low or high tick counts differ from max(`reload`,1) or max(`reload`,1)+1. A counter that keeps running while a slave holds the line makes the measured high interval shorter than expected, and this is visible at the end of the first stretched period. A state stuck outside idle shows as `scl_drive_low` or a strobe still active one clock after `run` falls. The bench models the open-drain line and a slave that holds it for a set number of ticks. It counts ticks in each of the three line conditions across one full period.

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
  parameter int RW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic [RW-1:0] reload,
  input  logic          scl_in,
  output logic          scl_drive_low,
  output logic          low_strobe,
  output logic          high_strobe
);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_WAIT, S_HIGH} st_t;

  st_t           st;
  logic [RW-1:0] cnt;
  logic          sync1, sync2;
  logic          last_count;

  assign last_count    = (cnt <= RW'(1));
  assign scl_drive_low = (st == S_LOW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= scl_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      low_strobe  <= 1'b0;
      high_strobe <= 1'b0;
    end else begin
      low_strobe  <= 1'b0;
      high_strobe <= 1'b0;
      if (!run) begin
        st  <= S_IDLE;
        cnt <= reload;
      end else begin
        case (st)
          S_IDLE: begin
            cnt <= reload;
            if (tick) begin
              st         <= S_LOW;
              low_strobe <= 1'b1;
            end
          end
          S_LOW: if (tick) begin
            if (last_count) st <= S_WAIT;
            else            cnt <= cnt - 1'b1;
          end
          S_WAIT: if (tick && sync2) begin
            st          <= S_HIGH;
            cnt         <= reload;
            high_strobe <= 1'b1;
          end
          S_HIGH: if (tick) begin
            if (last_count) begin
              st         <= S_LOW;
              cnt        <= reload;
              low_strobe <= 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!scl_drive_low && !low_strobe && !high_strobe));

  p_low_start_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> low_strobe);

  p_frozen_in_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && run && !(tick && sync2)) |=> $stable(cnt));

  p_high_after_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    high_strobe |-> ($past(sync2) && !scl_drive_low));

  p_short_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOW && run && tick && last_count) |=> !scl_drive_low);

  p_strobes_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(low_strobe && high_strobe));

endmodule

// File: tb/scl_clock_gen_test.sv
module scl_clock_gen_test;
  localparam int RW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          run = 1'b0;
  logic [RW-1:0] reload = '0;
  logic          hold = 1'b0;
  logic          scl_line;
  logic          scl_drive_low, low_strobe, high_strobe;
  logic [1:0]    tc = '0;
  int            checks = 0;
  int            errors = 0;
  int            cycles = 0;

  assign scl_line = !(scl_drive_low || hold);

  scl_clock_gen #(.RW(RW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .reload(reload),
    .scl_in(scl_line), .scl_drive_low(scl_drive_low),
    .low_strobe(low_strobe), .high_strobe(high_strobe)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tc   <= tc + 2'd1;
    tick <= (tc == 2'd2);
    cycles <= cycles + 1;
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act %0d cycles exp below 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: act %0d exp %0d", tag, act, exp);
    end
  endtask

  localparam int NV = 7;
  localparam int VEC [NV][2] = '{'{5,0}, '{5,3}, '{1,0}, '{0,2}, '{9,7}, '{3,1}, '{0,0}};

  task automatic period(input int r, input int s);
    int lo = 0, hi = 0, sc = 0, hs = 0, m;
    bit started = 0, fin = 0;
    m = (r == 0) ? 1 : r;
    run = 1'b0;
    hold = 1'b0;
    repeat (8) @(negedge clk);
    reload = RW'(r);
    run = 1'b1;
    for (int i = 0; i < 4000 && !fin; i++) begin
      @(negedge clk);
      if (low_strobe) begin
        if (started) fin = 1;
        else started = 1;
      end
      if (started && !fin) begin
        if (high_strobe) hs++;
        if (s > 0 && sc == 0 && scl_drive_low) hold = 1'b1;
        if (tick) begin
          if (scl_drive_low) lo++;
          else if (!scl_line) begin
            sc++;
            if (sc == s) hold = 1'b0;
          end else hi++;
        end
      end
    end
    hold = 1'b0;
    chk(lo == m, (r == 0) ? "R5 low ticks, reload 0" : "R2 low ticks", lo, m);
    chk(sc == s, "R3 stretch ticks", sc, s);
    chk(hi == m + 1, (r == 0) ? "R5 high ticks, reload 0" : "R4 high ticks", hi, m + 1);
    chk(hs == 1, "R6 high strobes per period", hs, 1);
  endtask

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    chk(!scl_drive_low, "R8 drive in reset", scl_drive_low, 0);
    chk(!low_strobe && !high_strobe, "R8 strobes in reset", low_strobe | high_strobe, 0);
    rst_n = 1'b1;
    bad = 0;
    repeat (12) begin
      @(negedge clk);
      if (scl_drive_low || low_strobe || high_strobe) bad++;
    end
    chk(bad == 0, "R8 quiet after reset", bad, 0);

    for (int v = 0; v < NV; v++) period(VEC[v][0], VEC[v][1]);

    run = 1'b0;
    bad = 0;
    @(negedge clk);
    repeat (60) begin
      @(negedge clk);
      if (scl_drive_low || low_strobe || high_strobe) bad++;
    end
    chk(bad == 0, "R1 idle outputs", bad, 0);

    reload = RW'(20);
    run = 1'b1;
    for (int i = 0; i < 100 && !scl_drive_low; i++) @(negedge clk);
    chk(scl_drive_low, "R7 low reached", scl_drive_low, 1);
    repeat (10) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk(!scl_drive_low, "R7 release on run drop", scl_drive_low, 0);
    chk(scl_line, "R7 line floats high", scl_line, 1);

    run = 1'b1;
    hold = 1'b1;
    reload = RW'(2);
    for (int i = 0; i < 100 && !high_strobe; i++) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    hold = 1'b0;
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (high_strobe || low_strobe || scl_drive_low) bad++;
    end
    chk(bad == 0, "R1 no strobe after drop during stretch", bad, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule